// File: doc/BRIEF.md
# Four-Lane Coalescing Gather Unit

This block collects one 32-bit word for each of four lanes, where every lane supplies its own byte address. Memory is only read as whole aligned 128-bit lines. The unit works out which line each lane needs and reads each distinct line once. It then takes the right word out of each returned line and places it in the lane that asked for it. When all four lanes hold their word, it pulses `done` and presents the 128-bit vector on `result`. Lanes that share a line cost only one memory read, so a gather whose lanes all fall in one line needs one read, while a fully scattered gather needs four.

The request side is a valid/ready pair. A request is taken on a cycle where both `req_valid` and `req_ready` are high. `req_ready` is high only while the unit is idle, so an upstream source that holds `req_valid` simply waits. The memory read port is also valid/ready. `mem_rd_valid` and `mem_rd_line` stay frozen while `mem_rd_ready` is low. Responses come back on `mem_rsp_valid`/`mem_rsp_data` after a fixed latency, in issue order, with no back-pressure from the unit.

Top module: `lane_gather`

## Requirements
- R1: Out of reset `req_ready` is 1, and `done`, `mem_rd_valid`, `reads_issued` and `result` are all 0.
- R2: A request is accepted only when `req_ready` is high. `req_ready` drops in the cycle after acceptance and stays low until the `done` cycle. A `req_valid` held during that time has no effect on the gather in progress.
- R3: A lane's line address is its address bits [31:4], and bits [3:2] select the word within the 128-bit line, where word k is line bits [32k+31:32k]. Lane n's word appears at `result` bits [32n+31:32n], so lane 0 is the lowest word. Bits [1:0] are assumed zero.
- R4: Exactly one memory read is issued for each distinct line among the four lanes. At `done`, `reads_issued` equals the number of distinct lines.
- R5: Distinct lines are issued in ascending order of the lowest lane that uses each line.
- R6: Once `mem_rd_valid` is high it stays high, with `mem_rd_line` unchanged, until the cycle in which `mem_rd_ready` is high.
- R7: `done` is high for exactly one cycle, the cycle after the last needed response is taken. From then on `result` holds its value until fills for the next accepted request begin.
- R8: A gather whose four addresses all lie in one line issues exactly one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Gather request present |
| req_ready | output | 1 | Unit idle, can take a request |
| req_addr | input | 128 | Four byte addresses, lane n at bits [32n+31:32n] |
| mem_rd_valid | output | 1 | Line read request |
| mem_rd_ready | input | 1 | Memory takes the read |
| mem_rd_line | output | 28 | Line address (byte address bits [31:4]) |
| mem_rsp_valid | input | 1 | Line data returned |
| mem_rsp_data | input | 128 | Returned line, word k at bits [32k+31:32k] |
| done | output | 1 | One-cycle completion pulse |
| result | output | 128 | Gathered vector, lane n at bits [32n+31:32n] |
| reads_issued | output | 3 | Reads issued for the current or last gather |

## Verification
The assertions take for granted that memory returns exactly one response for every accepted read, in issue order, and never while the unit is idle. They also assume that requests carry word-aligned addresses. The bench memory model meets these conditions by construction: it is a fixed-depth delay pipe fed only by read handshakes, so every response matches one read and keeps its order. All request addresses are built from a line number and a word index, with the two low bits zero. In one pass `mem_rd_ready` is held high. In a second pass it is driven by a shift-register sequence, so the hold rule on the read port is exercised under stalls.

// File: rtl/lane_gather_pkg.sv
package lane_gather_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } gstate_e;
endpackage

// File: rtl/gather_dedup.sv
module gather_dedup #(
  parameter int LANES   = 4,
  parameter int LINE_AW = 28,
  parameter int LIDX    = 2,
  parameter int CNT_W   = 3
) (
  input  logic [LANES*LINE_AW-1:0] lines,
  output logic [LANES*LIDX-1:0]    owner,
  output logic [LANES-1:0]         leader,
  output logic [CNT_W-1:0]         distinct
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LIDX-1:0] own;
    always_comb begin
      own = LIDX'(i);
      // scanning downward leaves the lowest matching lane
      for (int j = i - 1; j >= 0; j--) begin
        if (lines[j*LINE_AW +: LINE_AW] == lines[i*LINE_AW +: LINE_AW])
          own = LIDX'(j);
      end
    end
    assign owner[i*LIDX +: LIDX] = own;
    assign leader[i] = (own == LIDX'(i));
  end

  always_comb begin
    distinct = '0;
    for (int i = 0; i < LANES; i++)
      distinct = distinct + CNT_W'(leader[i]);
  end
endmodule

// File: rtl/gather_issue.sv
module gather_issue #(
  parameter int LANES   = 4,
  parameter int LINE_AW = 28,
  parameter int LIDX    = 2,
  parameter int CNT_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [LANES-1:0]         start_leader,
  input  logic [LANES*LINE_AW-1:0] start_lines,
  output logic                     mem_rd_valid,
  input  logic                     mem_rd_ready,
  output logic [LINE_AW-1:0]       mem_rd_line,
  output logic [CNT_W-1:0]         issued_cnt,
  output logic [LANES*LIDX-1:0]    order
);
  logic [LANES-1:0]         pending;
  logic [LANES*LINE_AW-1:0] lines_q;
  logic [LIDX-1:0]          pick;
  logic                     hs;

  always_comb begin
    pick = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (pending[i]) pick = LIDX'(i);
  end

  assign mem_rd_valid = |pending;
  assign mem_rd_line  = lines_q[pick*LINE_AW +: LINE_AW];
  assign hs           = mem_rd_valid && mem_rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending    <= '0;
      lines_q    <= '0;
      issued_cnt <= '0;
      order      <= '0;
    end else if (start) begin
      pending    <= start_leader;
      lines_q    <= start_lines;
      issued_cnt <= '0;
    end else if (hs) begin
      pending[pick] <= 1'b0;
      order[issued_cnt[LIDX-1:0]*LIDX +: LIDX] <= pick;
      issued_cnt <= issued_cnt + 1'b1;
    end
  end

  a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_line));
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    issued_cnt <= CNT_W'(LANES));
endmodule

// File: rtl/gather_fill.sv
module gather_fill #(
  parameter int LANES  = 4,
  parameter int WW     = 32,
  parameter int LINE_W = 128,
  parameter int WSEL_W = 2,
  parameter int LIDX   = 2,
  parameter int CNT_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     rsp_valid,
  input  logic [LINE_W-1:0]        rsp_data,
  input  logic [LANES*LIDX-1:0]    order,
  input  logic [LANES*LIDX-1:0]    owner,
  input  logic [LANES*WSEL_W-1:0]  wsel,
  output logic [LANES*WW-1:0]      result,
  output logic                     finish,
  output logic                     done
);
  logic [CNT_W-1:0] rsp_idx;
  logic [LIDX-1:0]  head;
  logic [LANES-1:0] hit, filled;

  assign head = order[rsp_idx[LIDX-1:0]*LIDX +: LIDX];

  for (genvar i = 0; i < LANES; i++) begin : g_hit
    assign hit[i] = rsp_valid && (owner[i*LIDX +: LIDX] == head);
  end

  assign finish = rsp_valid && (&(filled | hit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_idx <= '0;
      filled  <= '0;
      result  <= '0;
      done    <= 1'b0;
    end else begin
      done <= finish;
      if (start) begin
        rsp_idx <= '0;
        filled  <= '0;
      end else if (rsp_valid) begin
        rsp_idx <= rsp_idx + 1'b1;
        filled  <= filled | hit;
      end
      for (int i = 0; i < LANES; i++)
        if (hit[i])
          result[i*WW +: WW] <= rsp_data[wsel[i*WSEL_W +: WSEL_W]*WW +: WW];
    end
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_fill_once: assert property (@(posedge clk) disable iff (!rst_n)
    !start |-> (hit & filled) == '0);
endmodule

// File: rtl/lane_gather.sv
module lane_gather
  import lane_gather_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int AW         = 32,
  parameter int WW         = 32,
  parameter int LINE_WORDS = 4,
  localparam int LINE_W    = LINE_WORDS * WW,
  localparam int OFF_BITS  = $clog2(LINE_W / 8),
  localparam int BYTE_BITS = $clog2(WW / 8),
  localparam int WSEL_W    = $clog2(LINE_WORDS),
  localparam int LINE_AW   = AW - OFF_BITS,
  localparam int LIDX      = $clog2(LANES),
  localparam int CNT_W     = $clog2(LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [LANES*AW-1:0]   req_addr,
  output logic                  mem_rd_valid,
  input  logic                  mem_rd_ready,
  output logic [LINE_AW-1:0]    mem_rd_line,
  input  logic                  mem_rsp_valid,
  input  logic [LINE_W-1:0]     mem_rsp_data,
  output logic                  done,
  output logic [LANES*WW-1:0]   result,
  output logic [CNT_W-1:0]      reads_issued
);
  gstate_e                 state;
  logic                    accept, finish;
  logic [LANES*LINE_AW-1:0] req_lines;
  logic [LANES*WSEL_W-1:0]  req_wsel;
  logic [LANES*LIDX-1:0]    owner_c, owner_q, order;
  logic [LANES-1:0]         leader_c;
  logic [CNT_W-1:0]         distinct_c, distinct_q;
  logic [LANES*WSEL_W-1:0]  wsel_q;

  for (genvar i = 0; i < LANES; i++) begin : g_split
    assign req_lines[i*LINE_AW +: LINE_AW] = req_addr[i*AW + OFF_BITS +: LINE_AW];
    assign req_wsel[i*WSEL_W +: WSEL_W]    = req_addr[i*AW + BYTE_BITS +: WSEL_W];
  end

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  gather_dedup #(.LANES(LANES), .LINE_AW(LINE_AW), .LIDX(LIDX), .CNT_W(CNT_W)) u_dedup (
    .lines(req_lines), .owner(owner_c), .leader(leader_c), .distinct(distinct_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      owner_q    <= '0;
      wsel_q     <= '0;
      distinct_q <= '0;
    end else if (accept) begin
      state      <= ST_BUSY;
      owner_q    <= owner_c;
      wsel_q     <= req_wsel;
      distinct_q <= distinct_c;
    end else if (finish) begin
      state      <= ST_IDLE;
    end
  end

  gather_issue #(.LANES(LANES), .LINE_AW(LINE_AW), .LIDX(LIDX), .CNT_W(CNT_W)) u_issue (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_leader(leader_c),
    .start_lines(req_lines), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_line(mem_rd_line), .issued_cnt(reads_issued), .order(order)
  );

  gather_fill #(.LANES(LANES), .WW(WW), .LINE_W(LINE_W), .WSEL_W(WSEL_W),
                .LIDX(LIDX), .CNT_W(CNT_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .start(accept), .rsp_valid(mem_rsp_valid),
    .rsp_data(mem_rsp_data), .order(order), .owner(owner_q), .wsel(wsel_q),
    .result(result), .finish(finish), .done(done)
  );

  a_r4_reads_match: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> reads_issued == distinct_q);
  a_r2_no_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE |-> !mem_rd_valid);
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE |=> $stable(result));
  a_r2_rsp_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> state == ST_BUSY);
endmodule

// File: tb/lane_gather_tb.sv
module lane_gather_tb;
  localparam int LAT = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, req_valid, req_ready, mem_rd_valid, mem_rd_ready;
  logic [127:0]  req_addr, mem_rsp_data, result;
  logic [27:0]   mem_rd_line;
  logic          mem_rsp_valid, done;
  logic [2:0]    reads_issued;

  lane_gather u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_line(mem_rd_line), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .result(result),
    .reads_issued(reads_issued)
  );

  int n_chk = 0, n_bad = 0;
  logic stall_mode = 1'b0;

  function automatic logic [31:0] word_of(logic [29:0] wa);
    return {2'b00, wa} * 32'h9E3779B1 + 32'h01234567;
  endfunction

  function automatic logic [127:0] line_data(logic [27:0] l);
    logic [127:0] d;
    for (int w = 0; w < 4; w++) d[w*32 +: 32] = word_of({l, 2'(w)});
    return d;
  endfunction

  // memory model: fixed-latency pipe, read log, hold monitor
  logic [LAT-1:0] pv;
  logic [27:0]    pl [LAT];
  logic [7:0]     lfsr;
  logic [27:0]    log_line [16];
  logic [3:0]     log_n;
  logic           prev_wait;
  logic [27:0]    prev_line;
  int             hold_err;

  assign mem_rsp_valid = pv[LAT-1];
  assign mem_rsp_data  = line_data(pl[LAT-1]);

  always @(posedge clk) begin
    if (!rst_n) begin
      pv <= '0; lfsr <= 8'h5B; mem_rd_ready <= 1'b1; log_n <= '0;
      prev_wait <= 1'b0; prev_line <= '0; hold_err <= 0;
      for (int k = 0; k < LAT; k++) pl[k] <= '0;
    end else begin
      pv    <= {pv[LAT-2:0], mem_rd_valid && mem_rd_ready};
      pl[0] <= mem_rd_line;
      for (int k = 1; k < LAT; k++) pl[k] <= pl[k-1];
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_rd_ready <= stall_mode ? lfsr[0] : 1'b1;
      if (mem_rd_valid && mem_rd_ready) begin
        log_line[log_n] <= mem_rd_line;
        log_n <= log_n + 1'b1;
      end
      if (prev_wait && !(mem_rd_valid && mem_rd_line == prev_line)) hold_err <= hold_err + 1;
      prev_wait <= mem_rd_valid && !mem_rd_ready;
      prev_line <= mem_rd_line;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  bit timed_out = 1'b0;

  task automatic do_gather(input logic [27:0] ln [4], input logic [1:0] wo [4]);
    logic [127:0] a, held;
    logic [27:0]  eord [4];
    int           nd, cyc;
    logic [3:0]   base;
    bit           first;
    for (int i = 0; i < 4; i++) a[i*32 +: 32] = {ln[i], wo[i], 2'b00};
    while (!req_ready) @(negedge clk);
    base = log_n;
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    chk(req_ready == 1'b0, "R2 ready low after accept", 128'(req_ready), 128'(0));
    req_addr = ~a;                      // held junk request, must be ignored
    cyc = 0;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    req_valid = 1'b0;
    if (!done) begin
      chk(1'b0, "R7 done timeout", 128'(cyc), 128'(200));
      timed_out = 1'b1;
      return;
    end
    nd = 0;
    for (int i = 0; i < 4; i++) begin
      first = 1'b1;
      for (int j = 0; j < i; j++) if (ln[j] == ln[i]) first = 1'b0;
      if (first) begin eord[nd] = ln[i]; nd++; end
    end
    chk(reads_issued == 3'(nd), "R4 read count", 128'(reads_issued), 128'(nd));
    if (nd == 1) chk(reads_issued == 3'd1, "R8 single line one read", 128'(reads_issued), 128'(1));
    for (int k = 0; k < nd; k++)
      chk(log_line[4'(base + 4'(k))] == eord[k], "R5 issue order",
          128'(log_line[4'(base + 4'(k))]), 128'(eord[k]));
    for (int i = 0; i < 4; i++)
      chk(result[i*32 +: 32] == word_of({ln[i], wo[i]}), "R3 lane word",
          128'(result[i*32 +: 32]), 128'(word_of({ln[i], wo[i]})));
    held = result;
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", 128'(done), 128'(0));
    @(negedge clk);
    chk(result == held, "R7 result hold", result, held);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=expired exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [27:0] ln [4];
    logic [1:0]  wo [4];
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", 128'(req_ready), 128'(1));
    chk(done == 1'b0, "R1 done", 128'(done), 128'(0));
    chk(mem_rd_valid == 1'b0, "R1 rd_valid", 128'(mem_rd_valid), 128'(0));
    chk(reads_issued == 3'd0, "R1 count", 128'(reads_issued), 128'(0));
    chk(result == '0, "R1 result", result, 128'(0));
    for (int pass = 0; pass < 2 && !timed_out; pass++) begin
      stall_mode = pass[0];
      for (int pat = 0; pat < 256 && !timed_out; pat++) begin
        for (int i = 0; i < 4; i++) begin
          int c = (pat >> (2 * i)) & 3;
          ln[i] = 28'h0000100 + 28'(pat) * 28'h1000 + 28'(c * c * 7);
          wo[i] = 2'(i + pat + pass);
        end
        do_gather(ln, wo);
      end
    end
    chk(hold_err == 0, "R6 read hold under stall", 128'(hold_err), 128'(0));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule